// File: doc/BRIEF.md
# Serial Control Register Bank for a Multichannel Volume and Selector Device

This block is the digital control front end of an eight-channel audio volume and input-selector device. A host sends 24-bit frames over three wires: a serial clock, a data line and a load strobe. The block samples these lines into a faster system clock. It shifts the frame in one bit per serial clock rise and commits it on the strobe's rising edge. A three-bit format code at the top of each frame picks one of five register images to update. One image holds the selector, attenuator, gain, record and mute settings. Each of the other four holds the volume codes of one channel pair.

The decoded images drive the analog section directly. The outputs are the main and sub input selector indices, the ADC attenuator code, the input and output gain codes, the record enables, the multi-input controls, a global mute, and eight 8-bit volume codes. Each volume code comes with its own mute flag. Reset loads the power-on defaults.

Top module: `sctl_bank`

## Requirements
- R1: After reset every mode field is 0 (selectors off, 0 dB attenuation and gains, record and mutes off), every volume code is 255, and every volume mute flag is 1.
- R2: Data is sampled on each rising edge of the serial clock. A frame is the last 24 bits sampled, and the first bit sent lands in bit 0 (D0).
- R3: No output changes while bits are being shifted or while the strobe stays low. Outputs change only after a rising edge of the strobe.
- R4: Frame bits D23..D21 are the format code. Code 000 updates the mode image. Codes 001, 010, 011 and 100 update the volume pairs FL/FR, C/SW, SL/SR and SBL/SBR, which are channels 0/1, 2/3, 4/5 and 6/7. In a volume frame, D7..D0 goes to the even channel and D15..D8 to the odd channel. Channel c appears on `vol_o[8c+7:8c]`.
- R5: A frame with format code 101, 110 or 111 changes no output.
- R6: In a mode frame, D3..D0 is the main selector and D7..D4 is the sub selector. A selector value from 0 to 9 is stored. A value above 9 leaves that selector at its previous value, and the other fields of the frame still apply.
- R7: In a mode frame, the fields are placed as follows. D9..D8 is the ADC attenuator code. D10 and D11 are the two record enables. D12 selects the multi input. D13 is the multi-input mute. D14 selects the front volume source. D16..D15 is the input gain code. D18..D17 is the output gain code. D19 is the global mute.
- R8: A volume code from 0 to 198 is a plain attenuation code. A code from 199 to 255 sets that channel's mute flag, and a lower code clears it.
- R9: A strobe rise presented to the pins before system clock edge k appears on the outputs right after edge k+2: two synchroniser stages, then the commit register.
- R10: If more than 24 bits are shifted before the strobe, only the last 24 bits form the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Frame commit strobe |
| main_sel_o | output | 4 | Main input selector index (0 = off) |
| sub_sel_o | output | 4 | Sub input selector index (0 = off) |
| adc_att_o | output | 2 | ADC input attenuator code |
| rec1_en_o | output | 1 | Record output 1 enable |
| rec2_en_o | output | 1 | Record output 2 enable |
| multi_sel_o | output | 1 | Multi input select |
| multi_mute_o | output | 1 | Multi input mute |
| front_src_o | output | 1 | Front volume source select |
| in_gain_o | output | 2 | Input gain code |
| out_gain_o | output | 2 | Output gain code |
| all_mute_o | output | 1 | Global output mute |
| vol_o | output | 64 | Eight 8-bit volume codes, channel c at bits 8c+7..8c |
| vol_mute_o | output | 8 | Per-channel mute flag for volume codes 199 and above |

## Verification
Every output is due exactly three system clocks after the strobe edge is driven on the pins: two synchroniser stages and then the commit register. The serial shift itself never shows on the outputs. The reference model starts a three-cycle countdown when it drives the strobe. It applies its decoded update at the sample that follows the third rising edge, and it compares every output at every cycle. An early or late commit therefore fails on the cycle where it occurs. Outputs sampled during shifting, idle gaps and ignored frames must equal the held values.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
    localparam int FRAME_W   = 24;
    localparam int FMT_LSB   = 21;
    localparam int FMT_W     = 3;
    localparam int NUM_CH    = 8;
    localparam int VOL_W     = 8;
    localparam int SEL_W     = 4;
    localparam int MAX_SEL   = 9;
    localparam int MUTE_MIN  = 199;
    localparam int NUM_PAIRS = NUM_CH / 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_MODE  = 3'd0,
        FMT_FRONT = 3'd1,
        FMT_CSW   = 3'd2,
        FMT_SIDE  = 3'd3,
        FMT_BACK  = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [SEL_W-1:0] main_sel;
        logic [SEL_W-1:0] sub_sel;
        logic [1:0]       adc_att;
        logic             rec1;
        logic             rec2;
        logic             multi_sel;
        logic             multi_mute;
        logic             front_src;
        logic [1:0]       in_gain;
        logic [1:0]       out_gain;
        logic             all_mute;
    } mode_t;

    function automatic logic sel_valid(input logic [SEL_W-1:0] code);
        return code <= SEL_W'(MAX_SEL);
    endfunction

    function automatic logic vol_is_mute(input logic [VOL_W-1:0] code);
        return code >= VOL_W'(MUTE_MIN);
    endfunction

    function automatic mode_t decode_mode(input logic [FRAME_W-1:0] f, input mode_t prev);
        mode_t m;
        m.main_sel   = sel_valid(f[3:0]) ? f[3:0] : prev.main_sel;
        m.sub_sel    = sel_valid(f[7:4]) ? f[7:4] : prev.sub_sel;
        m.adc_att    = f[9:8];
        m.rec1       = f[10];
        m.rec2       = f[11];
        m.multi_sel  = f[12];
        m.multi_mute = f[13];
        m.front_src  = f[14];
        m.in_gain    = f[16:15];
        m.out_gain   = f[18:17];
        m.all_mute   = f[19];
        return m;
    endfunction
endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
module sctl_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o
);
    logic [LINES-1:0] stage_q [STAGES];
    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = stage_q[STAGES-1] & ~prev_q;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_chk
            // R2: an edge is reported as a single-cycle pulse
            a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
                rise_o[i] |=> !rise_o[i]);
        end
    endgenerate
endmodule

// File: rtl/sctl_shifter.sv
`timescale 1ns/1ps
module sctl_shifter #(
    parameter int FRAME_W = sctl_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_o
);
    always_ff @(posedge clk) begin
        if (rst)           frame_o <= '0;
        else if (shift_en) frame_o <= {din, frame_o[FRAME_W-1:1]};
    end
endmodule

// File: rtl/sctl_regs.sv
`timescale 1ns/1ps
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int V_W    = VOL_W,
    localparam int PAIRS = N_CH / 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic [FRAME_W-1:0]    frame,
    output mode_t                 mode_q,
    output logic [N_CH*V_W-1:0]   vol_q,
    output logic [N_CH-1:0]       vol_mute
);
    logic [FMT_W-1:0] fmt;
    assign fmt = frame[FMT_LSB +: FMT_W];

    always_ff @(posedge clk) begin
        if (rst)                                   mode_q <= '0;
        else if (commit && fmt == FMT_W'(FMT_MODE)) mode_q <= decode_mode(frame, mode_q);
    end

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            logic [2*V_W-1:0] pair_q;
            always_ff @(posedge clk) begin
                if (rst)                                  pair_q <= '1;
                else if (commit && fmt == FMT_W'(p + 1))  pair_q <= frame[2*V_W-1:0];
            end
            assign vol_q[p*2*V_W +: 2*V_W] = pair_q;
        end
        for (genvar c = 0; c < N_CH; c++) begin : g_mute
            assign vol_mute[c] = vol_is_mute(vol_q[c*V_W +: V_W]);
        end
    endgenerate

    // R3: images hold unless a commit pulse arrives
    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(mode_q) && $stable(vol_q)));
    // R5: unused format codes leave every image untouched
    a_r5_bad_format_ignored: assert property (@(posedge clk) disable iff (rst)
        (commit && fmt > FMT_W'(FMT_BACK)) |=> ($stable(mode_q) && $stable(vol_q)));
    // R6: stored selectors never exceed the last input
    a_r6_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        (mode_q.main_sel <= SEL_W'(MAX_SEL)) && (mode_q.sub_sel <= SEL_W'(MAX_SEL)));
    // R1: the cycle after reset shows the defaults
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && vol_q == '1 && vol_mute == '1));
endmodule

// File: rtl/sctl_bank.sv
`timescale 1ns/1ps
module sctl_bank
    import sctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_clk_i,
    input  logic                    ser_data_i,
    input  logic                    ser_load_i,
    output logic [SEL_W-1:0]        main_sel_o,
    output logic [SEL_W-1:0]        sub_sel_o,
    output logic [1:0]              adc_att_o,
    output logic                    rec1_en_o,
    output logic                    rec2_en_o,
    output logic                    multi_sel_o,
    output logic                    multi_mute_o,
    output logic                    front_src_o,
    output logic [1:0]              in_gain_o,
    output logic [1:0]              out_gain_o,
    output logic                    all_mute_o,
    output logic [NUM_CH*VOL_W-1:0] vol_o,
    output logic [NUM_CH-1:0]       vol_mute_o
);
    localparam int IDX_CLK  = 0;
    localparam int IDX_DATA = 1;
    localparam int IDX_LOAD = 2;

    logic [2:0]         level, rise;
    logic [FRAME_W-1:0] frame;
    mode_t              mode_q;

    sctl_sync #(.LINES(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .pin_i({ser_load_i, ser_data_i, ser_clk_i}),
        .level_o(level), .rise_o(rise)
    );

    sctl_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst),
        .shift_en(rise[IDX_CLK]), .din(level[IDX_DATA]),
        .frame_o(frame)
    );

    sctl_regs #(.N_CH(NUM_CH), .V_W(VOL_W)) u_regs (
        .clk(clk), .rst(rst),
        .commit(rise[IDX_LOAD]), .frame(frame),
        .mode_q(mode_q), .vol_q(vol_o), .vol_mute(vol_mute_o)
    );

    assign main_sel_o   = mode_q.main_sel;
    assign sub_sel_o    = mode_q.sub_sel;
    assign adc_att_o    = mode_q.adc_att;
    assign rec1_en_o    = mode_q.rec1;
    assign rec2_en_o    = mode_q.rec2;
    assign multi_sel_o  = mode_q.multi_sel;
    assign multi_mute_o = mode_q.multi_mute;
    assign front_src_o  = mode_q.front_src;
    assign in_gain_o    = mode_q.in_gain;
    assign out_gain_o   = mode_q.out_gain;
    assign all_mute_o   = mode_q.all_mute;
endmodule

// File: tb/sim_sctl_bank.sv
`timescale 1ns/1ps
module sim_sctl_bank;
    logic clk = 0, rst = 1;
    logic sclk = 0, sdata = 0, sload = 0;
    logic [3:0] main_sel, sub_sel;
    logic [1:0] adc_att, in_gain, out_gain;
    logic rec1, rec2, msel, mmute, fsrc, allm;
    logic [63:0] vol;
    logic [7:0]  vmute;

    always #4 clk = ~clk;

    sctl_bank u0 (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdata), .ser_load_i(sload),
        .main_sel_o(main_sel), .sub_sel_o(sub_sel), .adc_att_o(adc_att),
        .rec1_en_o(rec1), .rec2_en_o(rec2), .multi_sel_o(msel), .multi_mute_o(mmute),
        .front_src_o(fsrc), .in_gain_o(in_gain), .out_gain_o(out_gain),
        .all_mute_o(allm), .vol_o(vol), .vol_mute_o(vmute)
    );

    int errors = 0, checks = 0;
    string phase = "R1";
    bit mon_on = 0, done = 0;

    // reference model state
    int e_main, e_sub, e_rest;
    int e_vol [8];
    bit q [$];
    logic [23:0] pend_frame;
    int pend_cnt = 0;

    task automatic chk(string req, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s actual=%0d expected=%0d at %0t", req, phase, nm, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_main = 0; e_sub = 0; e_rest = 0;
        for (int c = 0; c < 8; c++) e_vol[c] = 255;
        q.delete();
        for (int i = 0; i < 24; i++) q.push_back(1'b0);
    endtask

    task automatic model_apply(logic [23:0] f);
        int fmt;
        fmt = int'(f[23:21]);
        if (fmt == 0) begin
            if (f[3:0] <= 9) e_main = int'(f[3:0]);
            if (f[7:4] <= 9) e_sub  = int'(f[7:4]);
            e_rest = int'(f[19:8]);
        end else if (fmt <= 4) begin
            e_vol[2*(fmt-1)]   = int'(f[7:0]);
            e_vol[2*(fmt-1)+1] = int'(f[15:8]);
        end
    endtask

    // compare every cycle, 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (mon_on) begin
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) model_apply(pend_frame); // R9: due after third edge
            end
            chk("R6", "main_sel", int'(main_sel), e_main);
            chk("R6", "sub_sel", int'(sub_sel), e_sub);
            chk("R7", "mode_fields",
                int'({allm, out_gain, in_gain, fsrc, mmute, msel, rec2, rec1, adc_att}), e_rest);
            for (int c = 0; c < 8; c++) begin
                chk("R4", $sformatf("vol[%0d]", c), int'(vol[8*c +: 8]), e_vol[c]);
                chk("R8", $sformatf("vol_mute[%0d]", c), int'(vmute[c]), (e_vol[c] >= 199) ? 1 : 0);
            end
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk); sdata = b;
        repeat (3) @(negedge clk);
        sclk = 1;
        q.push_back(b);
        if (q.size() > 24) void'(q.pop_front());
        repeat (5) @(negedge clk);
        sclk = 0;
    endtask

    task automatic strobe();
        @(negedge clk);
        sload = 1;
        for (int i = 0; i < 24; i++) pend_frame[i] = q[i];
        pend_cnt = 3;
        repeat (6) @(negedge clk);
        sload = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(logic [23:0] f);
        for (int i = 0; i < 24; i++) send_bit(f[i]);
        strobe();
    endtask

    function automatic logic [23:0] mk_mode(int mn, int sb, int att, int r1, int r2,
                                            int ms, int mm, int fs, int ig, int og, int am);
        logic [23:0] f = '0;
        f[3:0] = 4'(mn); f[7:4] = 4'(sb); f[9:8] = 2'(att);
        f[10] = 1'(r1); f[11] = 1'(r2); f[12] = 1'(ms); f[13] = 1'(mm); f[14] = 1'(fs);
        f[16:15] = 2'(ig); f[18:17] = 2'(og); f[19] = 1'(am);
        return f;
    endfunction

    function automatic logic [23:0] mk_vol(int fmt, int a, int b);
        return {3'(fmt), 5'b0, 8'(b), 8'(a)};
    endfunction

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: defaults right after reset
        chk("R1", "vol_o", (vol == '1) ? 1 : 0, 1);
        chk("R1", "vol_mute_o", int'(vmute), 255);
        chk("R1", "main_sel", int'(main_sel), 0);
        mon_on = 1;
        repeat (4) @(negedge clk);

        phase = "R7";   // R2 ordering via asymmetric field values
        send_frame(mk_mode(5, 9, 2, 1, 0, 1, 0, 1, 3, 1, 1));
        send_frame(mk_mode(1, 0, 1, 0, 1, 0, 1, 0, 2, 2, 0));
        phase = "R6";   // out-of-range main kept, other fields apply
        send_frame(mk_mode(12, 3, 3, 1, 1, 1, 1, 1, 1, 3, 1));
        send_frame(mk_mode(9, 15, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        phase = "R4";   // each pair, boundary codes for R8
        send_frame(mk_vol(1, 0, 198));
        send_frame(mk_vol(2, 199, 100));
        send_frame(mk_vol(3, 255, 1));
        send_frame(mk_vol(4, 50, 197));
        phase = "R5";   // unused format codes
        send_frame({3'd5, 21'h1F_FFFF});
        send_frame({3'd6, 21'h000123});
        send_frame({3'd7, 21'h0ABCDE});
        phase = "R3";   // partial shift without strobe must not change outputs
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        repeat (40) @(negedge clk);
        phase = "R10";  // 30 bits shifted, last 24 form the frame
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_frame(mk_vol(1, 17, 34));
        phase = "R9";   // back-to-back commits, exact latency tracked per cycle
        send_frame(mk_vol(4, 200, 0));
        send_frame(mk_mode(2, 4, 1, 1, 0, 0, 1, 0, 1, 0, 0));
        repeat (10) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (%s) actual=timeout expected=completion", phase);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule